// File: doc/BRIEF.md
# SDRAM Command Sequencing Monitor

This block watches the command pins of a four-bank single-data-rate SDRAM and reports, one clock after each rising edge, which command was seen and which banks it addressed. It keeps a small state machine for each bank: idle, open, bursting, or auto-precharging (an auto-precharge burst plus the row-precharge recovery that follows it). Against that state it checks the sequencing rules: mode-register and refresh commands need every bank idle, the bus must stay quiet for two cycles after a mode-register write, no read or write may interrupt an auto-precharge burst, and a bank may be reopened only after the row-precharge time. Each broken rule sets its own sticky error bit.

The monitor also turns the byte-mask pins into two expected-mask outputs. The write mask applies in the same cycle. The read high-impedance mask applies two cycles later. Only the A10/auto-precharge address line goes into the block, because the column and row bits take no part in any rule. Burst length, the row-precharge time and the read mask latency are parameters.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: `cmd_code` shows the command sampled at the previous rising edge: 0 deselect (cs_n high), 1 NOP, 2 mode-register set, 3 auto refresh, 4 self-refresh entry (refresh with cke low at that edge), 5 single-bank precharge, 6 all-bank precharge, 7 activate, 8 write, 9 write with auto precharge, 10 read, 11 read with auto precharge, 12 burst stop, 13 clock held. Code 13 applies to any edge whose previous edge sampled cke low. When cs_n is low, {ras_n,cas_n,we_n} selects the command: 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 NOP. A10 high selects the all-bank precharge and the auto-precharge variants.
- R2: `bank_sel` is one-hot for activate, read, write and single-bank precharge. The {ba1,ba0} bus gives 00 bit 0 (bank A), 10 bit 1 (bank B), 01 bit 2 (bank C) and 11 bit 3 (bank D). The all-bank precharge gives 4'b1111 whatever ba holds. All other commands give 0.
- R3: `bank_state[2i+1:2i]` holds the state of bank i: 0 idle, 1 open, 2 bursting, 3 auto-precharging. An activate opens an idle bank. A read or write moves an open bank to 2, or to 3 if A10 is set. A burst issued at edge k ends at edge k+BURST_LEN, and the bank returns to 1. A burst stop returns any bank in state 2 to 1 at once. A precharge closes the bank.
- R4: A mode-register set while any bank is not idle sets `err_vec` bit 0.
- R5: Any command other than NOP, deselect or clock-held at either of the two edges after a mode-register set sets `err_vec` bit 1. A command at the third edge is legal.
- R6: An auto refresh or self-refresh entry while any bank is not idle sets `err_vec` bit 2.
- R7: A read or write while a burst with auto precharge is in progress sets `err_vec` bit 3. At edge k+BURST_LEN, where k is the edge that issued the auto-precharge burst, reads and writes are legal again.
- R8: A bank that auto-precharges shows state 3 until it may reopen. An activate to that bank before edge k+BURST_LEN+T_RP sets `err_vec` bit 4 and is ignored. An activate at that edge opens the bank without error.
- R9: A read or write to a bank that is neither open nor in a plain burst sets `err_vec` bit 5. An activate to a bank that is open, bursting or in an auto-precharge burst sets bit 6, and the bank state does not change.
- R10: Every error bit stays set until `err_clr` is high at an edge. The clear takes effect at that edge, but an error detected at the same edge still sets its bit.
- R11: After edge n, `wr_mask` equals the dqm value sampled at edge n. After edge n+1, `rd_hiz` equals that same value, so it covers the read data of edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| err_clr | input | 1 | Clears all sticky error bits at the edge |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address {ba1,ba0} |
| a10_ap | input | 1 | Address line 10: all-bank / auto-precharge select |
| dqm | input | DQM_W | Byte mask lanes |
| cmd_code | output | 4 | Decoded command of the last edge (R1) |
| bank_sel | output | 4 | Banks addressed by the last command (R2) |
| bank_state | output | 8 | Two-bit state per bank, bank A lowest (R3) |
| err_vec | output | 7 | Sticky rule-violation bits (R4 to R10) |
| wr_mask | output | DQM_W | Expected write-data mask, latency 0 |
| rd_hiz | output | DQM_W | Expected read high-impedance mask, latency 2 |

## Verification
The bench aims at the cycle boundaries. It issues a command at the second and at the third edge after a mode-register set. It tests a read to another bank at exactly the edge that ends an auto-precharge burst. It sends activates one cycle before and exactly at the row-precharge limit. A counter off by one in any of these windows shows up as a missing or a spurious error bit, or as a bank state that leaves 3 at the wrong edge. The bench also uses B and C, whose {ba1,ba0} codes are asymmetric, so a swapped bank decode lights the wrong `bank_sel` bit. It drives a clear in the same cycle as a fresh violation, so a clear that wins over the new error loses that bit. It steps dqm through distinct lane patterns, so a read mask with the write mask's latency shows up one cycle early.

// File: rtl/sdram_mon_pkg.sv
// Shared types for the SDRAM command monitor: command codes,
// externally visible bank states and error bit positions.
package sdram_mon_pkg;

    localparam int NUM_BANKS = 4;
    localparam int ERR_W     = 7;

    // Error bit positions in the sticky vector
    localparam int ERR_MRS_BUSY = 0;
    localparam int ERR_MRS_GAP  = 1;
    localparam int ERR_REF_BUSY = 2;
    localparam int ERR_AP_RW    = 3;
    localparam int ERR_TRP      = 4;
    localparam int ERR_CLOSED   = 5;
    localparam int ERR_REOPEN   = 6;

    typedef enum logic [3:0] {
        CMD_DESEL  = 4'd0,
        CMD_NOP    = 4'd1,
        CMD_MRS    = 4'd2,
        CMD_AREF   = 4'd3,
        CMD_SREF   = 4'd4,
        CMD_PRE    = 4'd5,
        CMD_PREALL = 4'd6,
        CMD_ACT    = 4'd7,
        CMD_WR     = 4'd8,
        CMD_WRA    = 4'd9,
        CMD_RD     = 4'd10,
        CMD_RDA    = 4'd11,
        CMD_BST    = 4'd12,
        CMD_HOLD   = 4'd13
    } cmd_e;

    typedef enum logic [1:0] {
        BS_IDLE    = 2'd0,
        BS_OPEN    = 2'd1,
        BS_BURST   = 2'd2,
        BS_AUTOPRE = 2'd3
    } bank_vis_e;

    // True for any read or write flavour
    function automatic logic is_rw(cmd_e c);
        return (c == CMD_WR) || (c == CMD_WRA) || (c == CMD_RD) || (c == CMD_RDA);
    endfunction

    // True for commands that carry a bank address
    function automatic logic is_bank_cmd(cmd_e c);
        return is_rw(c) || (c == CMD_ACT) || (c == CMD_PRE);
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
// Combinational command decoder.
// Turns the sampled pin levels into a command code and a bank mask.
// Assumes cke_prev is the cke level registered at the previous edge.
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic                 cke_prev,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [1:0]           ba,
    input  logic                 a10_ap,
    output cmd_e                 cmd,
    output logic [NUM_BANKS-1:0] sel
);

    logic [NUM_BANKS-1:0] one_bank;

    // Command from the strobe pattern, gated by the clock enable history
    always_comb begin
        cmd = CMD_NOP;
        if (!cke_prev) begin
            cmd = CMD_HOLD;
        end else if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = cke ? CMD_AREF : CMD_SREF;
                3'b010:  cmd = a10_ap ? CMD_PREALL : CMD_PRE;
                3'b011:  cmd = CMD_ACT;
                3'b100:  cmd = a10_ap ? CMD_WRA : CMD_WR;
                3'b101:  cmd = a10_ap ? CMD_RDA : CMD_RD;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end

    // Four-way bank decode; ba[0] high picks the upper pair
    always_comb begin
        case (ba)
            2'b00:   one_bank = 4'b0001;
            2'b10:   one_bank = 4'b0010;
            2'b01:   one_bank = 4'b0100;
            default: one_bank = 4'b1000;
        endcase
    end

    // Mask of banks touched by this command
    always_comb begin
        if (cmd == CMD_PREALL)
            sel = '1;
        else if (is_bank_cmd(cmd))
            sel = one_bank;
        else
            sel = '0;
    end

endmodule

// File: rtl/sdram_bank_fsm.sv
// State tracker for one bank.
// Follows open, burst, auto-precharge and row-precharge recovery.
// Flags illegal activates and accesses aimed at this bank.
// Assumes hit is this bank's bit of the decoded bank mask.
module sdram_bank_fsm
    import sdram_mon_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  cmd_e       cmd,
    input  logic       hit,
    input  logic       ap,
    output logic [1:0] vis,
    output logic       idle,
    output logic       ap_busy,
    output logic       v_reopen,
    output logic       v_trp,
    output logic       v_closed
);

    localparam int MAXC  = (BURST_LEN > T_RP) ? BURST_LEN : T_RP;
    localparam int CNT_W = $clog2(MAXC + 1);

    typedef enum logic [2:0] {S_IDLE, S_OPEN, S_BURST, S_APB, S_REC} st_e;

    st_e              st;
    logic [CNT_W-1:0] cnt;
    logic             do_act, do_rw, do_pre;

    assign do_act = hit && (cmd == CMD_ACT);
    assign do_rw  = hit && is_rw(cmd);
    assign do_pre = hit && ((cmd == CMD_PRE) || (cmd == CMD_PREALL));

    // Bank state and burst / recovery countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= S_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (do_act) st <= S_OPEN;
                end
                S_OPEN: begin
                    if (do_rw) begin
                        st  <= ap ? S_APB : S_BURST;
                        cnt <= CNT_W'(BURST_LEN - 1);
                    end else if (do_pre) begin
                        st <= S_IDLE;
                    end
                end
                S_BURST: begin
                    if (do_pre) begin
                        st <= S_IDLE;
                    end else if (do_rw) begin
                        st  <= ap ? S_APB : S_BURST;
                        cnt <= CNT_W'(BURST_LEN - 1);
                    end else if (cmd == CMD_BST || cnt == '0) begin
                        st <= S_OPEN;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_APB: begin
                    if (cnt == '0) begin
                        st  <= S_REC;
                        cnt <= CNT_W'(T_RP - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_REC: begin
                    if (cnt == '0) st <= do_act ? S_OPEN : S_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Visible state encoding
    always_comb begin
        case (st)
            S_OPEN:        vis = BS_OPEN;
            S_BURST:       vis = BS_BURST;
            S_APB, S_REC:  vis = BS_AUTOPRE;
            default:       vis = BS_IDLE;
        endcase
    end

    assign idle     = (st == S_IDLE);
    assign ap_busy  = (st == S_APB) && (cnt != '0);
    assign v_reopen = do_act && ((st == S_OPEN) || (st == S_BURST) || (st == S_APB));
    assign v_trp    = do_act && (st == S_REC) && (cnt != '0);
    assign v_closed = do_rw && !((st == S_OPEN) || (st == S_BURST));

    // R3
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == S_IDLE) |-> (st == S_IDLE || st == S_OPEN));

    // R7
    ap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_APB && cnt != '0) |=> (st == S_APB));

endmodule

// File: rtl/sdram_rule_check.sv
// Rule checker: combines the bank flags with the decoded command.
// Runs the post-mode-set lockout and holds the sticky error vector.
// Assumes the bank flags describe the state before the current edge.
module sdram_rule_check
    import sdram_mon_pkg::*;
#(
    parameter int MRS_GAP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_clr,
    input  cmd_e             cmd,
    input  logic             all_idle,
    input  logic             any_ap_busy,
    input  logic             any_reopen,
    input  logic             any_trp,
    input  logic             any_closed,
    output logic [ERR_W-1:0] err_vec
);

    localparam int LOCK_W = $clog2(MRS_GAP + 1);

    logic [LOCK_W-1:0] lock;
    logic [ERR_W-1:0]  err_q, err_new;
    logic              real_cmd;

    assign real_cmd = (cmd != CMD_NOP) && (cmd != CMD_DESEL) && (cmd != CMD_HOLD);

    // Violations detected at this edge
    always_comb begin
        err_new               = '0;
        err_new[ERR_MRS_BUSY] = (cmd == CMD_MRS) && !all_idle;
        err_new[ERR_MRS_GAP]  = (lock != '0) && real_cmd;
        err_new[ERR_REF_BUSY] = ((cmd == CMD_AREF) || (cmd == CMD_SREF)) && !all_idle;
        err_new[ERR_AP_RW]    = is_rw(cmd) && any_ap_busy;
        err_new[ERR_TRP]      = any_trp;
        err_new[ERR_CLOSED]   = any_closed;
        err_new[ERR_REOPEN]   = any_reopen;
    end

    // Quiet-window countdown started by every mode-register set
    always_ff @(posedge clk) begin
        if (!rst_n)                lock <= '0;
        else if (cmd == CMD_MRS)   lock <= LOCK_W'(MRS_GAP);
        else if (lock != '0)       lock <= lock - 1'b1;
    end

    // Sticky error bits; new errors win over a same-edge clear
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (err_clr ? '0 : err_q) | err_new;
    end

    assign err_vec = err_q;

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(err_clr) |-> ((err_q & $past(err_q)) == $past(err_q)));

    // R5
    mrs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock != '0 && real_cmd) |=> err_q[ERR_MRS_GAP]);

endmodule

// File: rtl/sdram_dqm_pipe.sv
// Byte-mask latency pipes.
// The write mask follows dqm after one register.
// The read high-impedance mask runs through its own RD_LAT-stage shift chain.
module sdram_dqm_pipe #(
    parameter int DQM_W  = 2,
    parameter int RD_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DQM_W-1:0] dqm,
    output logic [DQM_W-1:0] wr_mask,
    output logic [DQM_W-1:0] rd_hiz
);

    logic [DQM_W-1:0] wr_q;
    logic [DQM_W-1:0] rd_pipe [RD_LAT];

    // Same-cycle write mask register
    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= dqm;
    end

    // Read-side delay chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RD_LAT; i++) rd_pipe[i] <= '0;
        end else begin
            rd_pipe[0] <= dqm;
            for (int i = 1; i < RD_LAT; i++) rd_pipe[i] <= rd_pipe[i-1];
        end
    end

    assign wr_mask = wr_q;
    assign rd_hiz  = rd_pipe[RD_LAT-1];

    generate
        if (RD_LAT > 1) begin : g_lat_chk
            // R11
            rd_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rd_hiz == $past(wr_mask, RD_LAT - 1));
        end
    endgenerate

endmodule

// File: rtl/sdram_cmd_monitor.sv
// Top of the SDRAM command sequencing monitor.
// Samples the command pins every rising edge and registers the decoded command and bank mask.
// Runs one state tracker per bank and flags rule violations.
// Assumes the pins are synchronous to clk.
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 3,
    parameter int MRS_GAP   = 2,
    parameter int DQM_W     = 2,
    parameter int RD_LAT    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   err_clr,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [1:0]             ba,
    input  logic                   a10_ap,
    input  logic [DQM_W-1:0]       dqm,
    output logic [3:0]             cmd_code,
    output logic [3:0]             bank_sel,
    output logic [2*NUM_BANKS-1:0] bank_state,
    output logic [ERR_W-1:0]       err_vec,
    output logic [DQM_W-1:0]       wr_mask,
    output logic [DQM_W-1:0]       rd_hiz
);

    logic                 cke_prev;
    cmd_e                 cmd, cmd_q;
    logic [NUM_BANKS-1:0] sel, sel_q;
    logic [NUM_BANKS-1:0] b_idle, b_apb, b_reopen, b_trp, b_closed;

    // Clock-enable history for the held-clock and self-refresh decode
    always_ff @(posedge clk) begin
        if (!rst_n) cke_prev <= 1'b1;
        else        cke_prev <= cke;
    end

    sdram_cmd_decode u_dec (
        .cke_prev (cke_prev),
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .ba       (ba),
        .a10_ap   (a10_ap),
        .cmd      (cmd),
        .sel      (sel)
    );

    // Registered copy of the decode for the outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_DESEL;
            sel_q <= '0;
        end else begin
            cmd_q <= cmd;
            sel_q <= sel;
        end
    end

    assign cmd_code = cmd_q;
    assign bank_sel = sel_q;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            sdram_bank_fsm #(
                .BURST_LEN (BURST_LEN),
                .T_RP      (T_RP)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .cmd      (cmd),
                .hit      (sel[b]),
                .ap       (a10_ap),
                .vis      (bank_state[2*b +: 2]),
                .idle     (b_idle[b]),
                .ap_busy  (b_apb[b]),
                .v_reopen (b_reopen[b]),
                .v_trp    (b_trp[b]),
                .v_closed (b_closed[b])
            );
        end
    endgenerate

    sdram_rule_check #(
        .MRS_GAP (MRS_GAP)
    ) u_rules (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_clr     (err_clr),
        .cmd         (cmd),
        .all_idle    (&b_idle),
        .any_ap_busy (|b_apb),
        .any_reopen  (|b_reopen),
        .any_trp     (|b_trp),
        .any_closed  (|b_closed),
        .err_vec     (err_vec)
    );

    sdram_dqm_pipe #(
        .DQM_W  (DQM_W),
        .RD_LAT (RD_LAT)
    ) u_dqm (
        .clk     (clk),
        .rst_n   (rst_n),
        .dqm     (dqm),
        .wr_mask (wr_mask),
        .rd_hiz  (rd_hiz)
    );

    // R2
    bank_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != CMD_PREALL) |-> $onehot0(sel_q));

endmodule

// File: tb/sdram_cmd_monitor_bench.sv
// Scoreboard bench: the driver queues expected output values per edge,
// and the monitor compares them at the falling edge.
module sdram_cmd_monitor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BL   = 4;
    localparam int TRP  = 3;
    localparam int DW   = 2;

    localparam int F_CMD = 0, F_SEL = 1, F_ST = 2, F_ERR = 3, F_WM = 4, F_RH = 5;

    logic          clk = 1'b0;
    logic          rst_n, err_clr, cke, cs_n, ras_n, cas_n, we_n, a10_ap;
    logic [1:0]    ba;
    logic [DW-1:0] dqm;
    logic [3:0]    cmd_code, bank_sel;
    logic [7:0]    bank_state;
    logic [6:0]    err_vec;
    logic [DW-1:0] wr_mask, rd_hiz;

    int checks = 0;
    int errors = 0;
    int ecnt   = 0;
    bit done   = 1'b0;

    typedef struct {
        int          cyc;
        int          fld;
        logic [31:0] val;
        string       tag;
    } item_t;
    item_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_monitor #(.BURST_LEN(BL), .T_RP(TRP), .DQM_W(DW)) u_sdram_cmd_monitor (
        .clk(clk), .rst_n(rst_n), .err_clr(err_clr), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10_ap(a10_ap),
        .dqm(dqm), .cmd_code(cmd_code), .bank_sel(bank_sel), .bank_state(bank_state),
        .err_vec(err_vec), .wr_mask(wr_mask), .rd_hiz(rd_hiz)
    );

    function automatic logic [31:0] field(int f);
        case (f)
            F_CMD:   return 32'(cmd_code);
            F_SEL:   return 32'(bank_sel);
            F_ST:    return 32'(bank_state);
            F_ERR:   return 32'(err_vec);
            F_WM:    return 32'(wr_mask);
            default: return 32'(rd_hiz);
        endcase
    endfunction

    task automatic check_now(int f, logic [31:0] v, string tag);
        logic [31:0] a;
        a = field(f);
        checks++;
        if (a !== v) begin
            errors++;
            $display("FAIL %s field %0d actual %0h expected %0h", tag, f, a, v);
        end
    endtask

    // Queue an expectation for the edge `off` edges ahead
    task automatic expect_v(int f, logic [31:0] v, string tag, int off = 1);
        item_t it;
        it.cyc = ecnt + off;
        it.fld = f;
        it.val = v;
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compare every item due at the edge just passed
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].cyc == ecnt) begin
                check_now(q[i].fld, q[i].val, q[i].tag);
                q.delete(i);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        ecnt++;
        err_clr = 1'b0;
    endtask

    task automatic drive(logic [2:0] rcw, logic [1:0] b, logic a);
        cs_n = 1'b0;
        {ras_n, cas_n, we_n} = rcw;
        ba = b;
        a10_ap = a;
        tick();
    endtask

    task automatic nop();                 drive(3'b111, 2'b00, 1'b0); endtask
    task automatic act(logic [1:0] b);    drive(3'b011, b, 1'b0);     endtask
    task automatic rd(logic [1:0] b, logic a); drive(3'b101, b, a);   endtask
    task automatic wr(logic [1:0] b, logic a); drive(3'b100, b, a);   endtask
    task automatic preall(logic [1:0] b); drive(3'b010, b, 1'b1);     endtask
    task automatic mrs();                 drive(3'b000, 2'b00, 1'b0); endtask
    task automatic refr();                drive(3'b001, 2'b00, 1'b0); endtask
    task automatic bst();                 drive(3'b110, 2'b00, 1'b0); endtask

    task automatic clear();
        expect_v(F_ERR, 0, "R10 clear");
        err_clr = 1'b1;
        nop();
    endtask

    initial begin
        rst_n = 1'b0; err_clr = 1'b0; cke = 1'b1; cs_n = 1'b0;
        {ras_n, cas_n, we_n} = 3'b111; ba = 2'b00; a10_ap = 1'b0; dqm = '0;
        repeat (3) tick();
        check_now(F_CMD, 0, "R1 reset");
        check_now(F_ST, 0, "R3 reset");
        check_now(F_ERR, 0, "R10 reset");
        check_now(F_RH, 0, "R11 reset");
        rst_n = 1'b1;
        nop();

        // R1 R2 R3: open all four banks with asymmetric bank codes
        expect_v(F_CMD, 7, "R1 act");
        expect_v(F_SEL, 4'b0010, "R2 bank B");
        expect_v(F_ST, 8'h04, "R3 B open");
        act(2'b10);
        expect_v(F_SEL, 4'b0100, "R2 bank C");
        expect_v(F_ST, 8'h14, "R3 C open");
        act(2'b01);
        expect_v(F_SEL, 4'b1000, "R2 bank D");
        act(2'b11);
        expect_v(F_SEL, 4'b0001, "R2 bank A");
        expect_v(F_ST, 8'h55, "R3 all open");
        act(2'b00);

        // R4: mode set with banks open
        expect_v(F_CMD, 2, "R1 mrs");
        expect_v(F_SEL, 0, "R2 mrs no bank");
        expect_v(F_ERR, 7'h01, "R4 mrs busy");
        mrs();
        nop(); nop();
        clear();

        // R6: auto refresh with banks open
        expect_v(F_CMD, 3, "R1 aref");
        expect_v(F_ERR, 7'h04, "R6 refresh busy");
        refr();
        clear();

        // R9: activate an open bank
        expect_v(F_ERR, 7'h40, "R9 reopen");
        expect_v(F_ST, 8'h55, "R9 reopen ignored");
        act(2'b00);
        clear();

        // R2: all-bank precharge ignores ba
        expect_v(F_CMD, 6, "R1 preall");
        expect_v(F_SEL, 4'b1111, "R2 preall");
        expect_v(F_ST, 0, "R3 all idle");
        preall(2'b01);

        // R9: read a closed bank
        expect_v(F_CMD, 10, "R1 rd");
        expect_v(F_ERR, 7'h20, "R9 closed");
        rd(2'b11, 1'b0);
        clear();

        // R4 R5: legal mode set, command at third edge is fine
        expect_v(F_ERR, 0, "R4 mrs idle");
        mrs();
        nop(); nop();
        expect_v(F_ERR, 0, "R5 third edge ok");
        expect_v(F_ST, 8'h01, "R3 A open");
        act(2'b00);
        preall(2'b00);
        mrs();
        nop();
        expect_v(F_ERR, 7'h02, "R5 second edge");
        act(2'b10);
        clear();
        preall(2'b00);

        // R6: refresh when idle, self refresh and held clock
        expect_v(F_ERR, 0, "R6 aref idle");
        refr();
        cke = 1'b0;
        expect_v(F_CMD, 4, "R1 sref");
        expect_v(F_ERR, 0, "R6 sref idle");
        refr();
        expect_v(F_CMD, 13, "R1 held");
        nop();
        cke = 1'b1;
        expect_v(F_CMD, 13, "R1 held exit");
        nop();
        expect_v(F_CMD, 1, "R1 nop");
        nop();

        // R3: plain burst, burst stop, natural end
        act(2'b00);
        nop();
        expect_v(F_ST, 8'h02, "R3 burst");
        rd(2'b00, 1'b0);
        expect_v(F_CMD, 12, "R1 bst");
        expect_v(F_ST, 8'h01, "R3 bst");
        bst();
        expect_v(F_CMD, 8, "R1 wr");
        expect_v(F_ST, 8'h02, "R3 wr burst", 1);
        expect_v(F_ST, 8'h02, "R3 burst last", BL);
        expect_v(F_ST, 8'h01, "R3 burst end", BL + 1);
        wr(2'b00, 1'b0);
        repeat (BL) nop();

        // R7 R8: auto precharge burst on A, conflicts on B
        act(2'b10);
        expect_v(F_CMD, 11, "R1 rda");
        expect_v(F_ST, 8'h07, "R8 A autopre");
        rd(2'b00, 1'b1);
        expect_v(F_ERR, 7'h08, "R7 rw during ap");
        expect_v(F_ST, 8'h0B, "R3 B burst");
        wr(2'b10, 1'b0);
        nop(); nop();
        expect_v(F_ERR, 7'h08, "R7 legal at burst end");
        rd(2'b10, 1'b0);
        nop();
        expect_v(F_ERR, 7'h18, "R8 early act");
        expect_v(F_ST, 8'h0B, "R8 early ignored");
        act(2'b00);
        expect_v(F_ERR, 7'h18, "R8 act at limit");
        expect_v(F_ST, 8'h09, "R8 reopened");
        act(2'b00);

        // R10: errors persist, same-edge error survives clear
        expect_v(F_ERR, 7'h18, "R10 sticky");
        nop();
        expect_v(F_ERR, 7'h40, "R10 clear vs new");
        err_clr = 1'b1;
        act(2'b00);
        clear();

        // R11: mask latencies
        dqm = 2'b01;
        expect_v(F_WM, 2'b01, "R11 wr lat0");
        expect_v(F_RH, 2'b00, "R11 rd not yet");
        nop();
        dqm = 2'b10;
        expect_v(F_WM, 2'b10, "R11 wr next");
        expect_v(F_RH, 2'b01, "R11 rd lat2");
        nop();
        dqm = 2'b00;
        expect_v(F_RH, 2'b10, "R11 rd second");
        nop();
        expect_v(F_RH, 2'b00, "R11 rd clear");
        nop();

        repeat (3) nop();
        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard %0d items unchecked, expected 0", q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule